// File: doc/BRIEF.md
# Transfer Overlay State Updater

This block keeps the working copy of one transfer descriptor on chip and moves it forward each time the transaction sequencer reports a data transaction. The copy holds the number of bytes still to be moved, the data toggle, a 12-bit byte offset inside the current 4 KB buffer page, and an index into a five-entry list of buffer page pointers. From the selected pointer and the offset it forms the address that the next transmit or receive uses.

A load strobe stands in for the descriptor fetch and fills every field in one cycle. The registered outputs stand in for the write-back path. Each cycle the sequencer may raise an advance strobe with a byte count and a success flag. A successful advance updates all four transfer fields together. An advance flagged as unsuccessful, such as an IN with a data PID mismatch, leaves every field as it was. A zero-byte transaction is legal and changes only the toggle. A count larger than what remains clamps the remaining total to zero and raises a sticky error flag.

Top module: `xfer_overlay_adv`

## Requirements
- R1: After reset all fields, the error flag and all pointers are zero. A `load_i` pulse copies the total, toggle, offset, page index and pointer list into the overlay and clears the error flag. All outputs show the new values one cycle later. A loaded page index above 4 is clamped to 4.
- R2: On a successful advance (`adv_i`=1, `adv_ok_i`=1) whose byte count does not exceed the remaining total, `len_o` drops by exactly that count on the next cycle.
- R3: On every successful advance, `tog_o` inverts on the next cycle.
- R4: On a successful advance, `ofs_o` becomes (offset + byte count) mod 4096. When the sum reaches 4096 or more, `page_o` increments by one.
- R5: `page_o` never exceeds 4. An offset carry while the index is already 4 leaves it at 4, and the offset still wraps.
- R6: An advance with `adv_ok_i`=0 leaves the total, toggle, offset, page index and error flag unchanged.
- R7: A successful advance with a byte count of 0 inverts the toggle and leaves the total, offset and page index unchanged. This also holds when the total is 0.
- R8: A successful advance with a byte count larger than the remaining total sets `len_o` to 0 and sets `err_o`. The toggle, offset and page still advance. `err_o` stays set until the next load.
- R9: `addr_o` equals the 20-bit pointer at list position `page_o`, in bits 31:12, joined to `ofs_o` in bits 11:0. Pointer n occupies bits [20n+19:20n] of `load_ptr_i`.
- R10: When `load_i` and `adv_i` are high in the same cycle, the load wins and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load overlay from descriptor fields |
| load_len_i | input | 15 | Total bytes to load |
| load_tog_i | input | 1 | Data toggle to load |
| load_ofs_i | input | 12 | Page offset to load |
| load_page_i | input | 3 | Page index to load |
| load_ptr_i | input | 100 | Five packed 20-bit page pointers |
| adv_i | input | 1 | Transaction completed, advance requested |
| adv_ok_i | input | 1 | 1: data moved successfully; 0: discard |
| adv_bytes_i | input | 11 | Bytes moved in the transaction |
| len_o | output | 15 | Remaining total bytes |
| tog_o | output | 1 | Current data toggle |
| ofs_o | output | 12 | Current page offset |
| page_o | output | 3 | Current page index |
| addr_o | output | 32 | Address for the next transaction |
| err_o | output | 1 | Byte count overrun seen since last load |

## Verification
The bench sweeps start offsets on both sides of the page edge, byte counts from zero to the maximum, and page indices including the last one. A design with a wrong carry would leave the page index behind or let it run past 4, and the generated address would then point into the wrong buffer. Remaining totals of zero and near-zero check for underflow: a plain subtractor would wrap to a huge total instead of clamping and flagging. Discarded advances, zero-length advances and a load colliding with an advance catch a design that flips the toggle on a mismatch, moves the offset on a zero count, or lets the advance override the fresh descriptor. A long pseudo-random sequence then compares every output against an arithmetic model.

// File: rtl/xov_pkg.sv
package xov_pkg;
    localparam int XOV_LEN_W   = 15;
    localparam int XOV_OFS_W   = 12;
    localparam int XOV_CNT_W   = 11;
    localparam int XOV_PTR_NUM = 5;
    localparam int XOV_ADDR_W  = 32;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_DROP = 2'd2,
        OP_MOVE = 2'd3
    } xov_op_e;
endpackage

// File: rtl/xov_len_ctr.sv
module xov_len_ctr #(
    parameter int LEN_W = 15,
    parameter int CNT_W = 11
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [CNT_W-1:0] bytes_i,
    output logic [LEN_W-1:0] len_next_o,
    output logic             overrun_o
);
    logic [LEN_W-1:0] bytes_ext;

    always_comb begin
        bytes_ext = LEN_W'(bytes_i);
        overrun_o = (bytes_ext > len_i);
        if (overrun_o) begin
            len_next_o = '0;
        end else begin
            len_next_o = len_i - bytes_ext;
        end
    end
endmodule

// File: rtl/xov_pos_adv.sv
module xov_pos_adv #(
    parameter int OFS_W   = 12,
    parameter int CNT_W   = 11,
    parameter int PTR_NUM = 5,
    parameter int PG_W    = 3
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [PG_W-1:0]  page_i,
    input  logic [CNT_W-1:0] bytes_i,
    output logic [OFS_W-1:0] ofs_next_o,
    output logic [PG_W-1:0]  page_next_o
);
    localparam logic [PG_W-1:0] PG_LAST = PG_W'(PTR_NUM - 1);

    logic [OFS_W:0] sum;

    always_comb begin
        sum         = {1'b0, ofs_i} + (OFS_W + 1)'(bytes_i);
        ofs_next_o  = sum[OFS_W-1:0];
        page_next_o = page_i;
        if (sum[OFS_W] && (page_i < PG_LAST)) begin
            page_next_o = page_i + 1'b1;
        end
    end
endmodule

// File: rtl/xov_addr_sel.sv
module xov_addr_sel #(
    parameter int PTR_NUM = 5,
    parameter int PB_W    = 20,
    parameter int OFS_W   = 12,
    parameter int PG_W    = 3
) (
    input  logic [PTR_NUM*PB_W-1:0] ptr_i,
    input  logic [PG_W-1:0]         page_i,
    input  logic [OFS_W-1:0]        ofs_i,
    output logic [PB_W+OFS_W-1:0]   addr_o
);
    logic [PB_W-1:0] ptr_arr [PTR_NUM];
    logic [PB_W-1:0] base;

    for (genvar g = 0; g < PTR_NUM; g++) begin : g_ptr
        assign ptr_arr[g] = ptr_i[g*PB_W +: PB_W];
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < PTR_NUM; i++) begin
            if (page_i == PG_W'(i)) begin
                base = ptr_arr[i];
            end
        end
        addr_o = {base, ofs_i};
    end
endmodule

// File: rtl/xfer_overlay_adv.sv
module xfer_overlay_adv
    import xov_pkg::*;
#(
    parameter  int LEN_W   = XOV_LEN_W,
    parameter  int OFS_W   = XOV_OFS_W,
    parameter  int CNT_W   = XOV_CNT_W,
    parameter  int PTR_NUM = XOV_PTR_NUM,
    parameter  int ADDR_W  = XOV_ADDR_W,
    localparam int PG_W    = $clog2(PTR_NUM),
    localparam int PB_W    = ADDR_W - OFS_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    load_i,
    input  logic [LEN_W-1:0]        load_len_i,
    input  logic                    load_tog_i,
    input  logic [OFS_W-1:0]        load_ofs_i,
    input  logic [PG_W-1:0]         load_page_i,
    input  logic [PTR_NUM*PB_W-1:0] load_ptr_i,
    input  logic                    adv_i,
    input  logic                    adv_ok_i,
    input  logic [CNT_W-1:0]        adv_bytes_i,
    output logic [LEN_W-1:0]        len_o,
    output logic                    tog_o,
    output logic [OFS_W-1:0]        ofs_o,
    output logic [PG_W-1:0]         page_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    err_o
);
    localparam logic [PG_W-1:0] PG_LAST = PG_W'(PTR_NUM - 1);

    typedef struct packed {
        logic [LEN_W-1:0]        len;
        logic                    tog;
        logic [OFS_W-1:0]        ofs;
        logic [PG_W-1:0]         page;
        logic                    err;
        logic [PTR_NUM*PB_W-1:0] ptr;
    } ovl_t;

    ovl_t    st_d, st_q;
    xov_op_e op;

    logic [LEN_W-1:0] len_sub;
    logic             overrun;
    logic [OFS_W-1:0] ofs_adv;
    logic [PG_W-1:0]  page_adv;

    xov_len_ctr #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) i_len (
        .len_i      (st_q.len),
        .bytes_i    (adv_bytes_i),
        .len_next_o (len_sub),
        .overrun_o  (overrun)
    );

    xov_pos_adv #(
        .OFS_W   (OFS_W),
        .CNT_W   (CNT_W),
        .PTR_NUM (PTR_NUM),
        .PG_W    (PG_W)
    ) i_pos (
        .ofs_i       (st_q.ofs),
        .page_i      (st_q.page),
        .bytes_i     (adv_bytes_i),
        .ofs_next_o  (ofs_adv),
        .page_next_o (page_adv)
    );

    xov_addr_sel #(
        .PTR_NUM (PTR_NUM),
        .PB_W    (PB_W),
        .OFS_W   (OFS_W),
        .PG_W    (PG_W)
    ) i_addr (
        .ptr_i  (st_q.ptr),
        .page_i (st_q.page),
        .ofs_i  (st_q.ofs),
        .addr_o (addr_o)
    );

    always_comb begin
        if (load_i) begin
            op = OP_LOAD;
        end else if (adv_i && adv_ok_i) begin
            op = OP_MOVE;
        end else if (adv_i) begin
            op = OP_DROP;
        end else begin
            op = OP_IDLE;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.len  = load_len_i;
                st_d.tog  = load_tog_i;
                st_d.ofs  = load_ofs_i;
                st_d.page = (load_page_i > PG_LAST) ? PG_LAST : load_page_i;
                st_d.err  = 1'b0;
                st_d.ptr  = load_ptr_i;
            end
            OP_MOVE: begin
                st_d.len  = len_sub;
                st_d.tog  = ~st_q.tog;
                st_d.ofs  = ofs_adv;
                st_d.page = page_adv;
                st_d.err  = st_q.err | overrun;
            end
            OP_DROP: begin
                st_d = st_q;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o  = st_q.len;
    assign tog_o  = st_q.tog;
    assign ofs_o  = st_q.ofs;
    assign page_o = st_q.page;
    assign err_o  = st_q.err;
endmodule

// File: rtl/xov_checker.sv
module xov_checker #(
    parameter int LEN_W   = 15,
    parameter int OFS_W   = 12,
    parameter int CNT_W   = 11,
    parameter int PTR_NUM = 5,
    parameter int PG_W    = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             load_i,
    input logic             adv_i,
    input logic             adv_ok_i,
    input logic [CNT_W-1:0] adv_bytes_i,
    input logic [LEN_W-1:0] len_o,
    input logic             tog_o,
    input logic [OFS_W-1:0] ofs_o,
    input logic [PG_W-1:0]  page_o,
    input logic             err_o
);
    logic mv;
    logic fits;
    assign mv   = adv_i && adv_ok_i && !load_i;
    assign fits = (LEN_W'(adv_bytes_i) <= len_o);

    p_len_sub_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mv && fits |=> len_o == $past(len_o) - LEN_W'($past(adv_bytes_i)));

    p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mv |=> tog_o != $past(tog_o));

    p_page_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        page_o <= PG_W'(PTR_NUM - 1));

    p_drop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i && !adv_ok_i && !load_i |=> $stable(len_o) && $stable(tog_o)
            && $stable(ofs_o) && $stable(page_o) && $stable(err_o));

    p_zero_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mv && adv_bytes_i == '0 |=> $stable(len_o) && $stable(ofs_o) && $stable(page_o));

    p_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mv && !fits |=> len_o == '0 && err_o);

    p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o && !load_i |=> err_o);

    p_load_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !err_o);
endmodule

bind xfer_overlay_adv xov_checker #(
    .LEN_W   (LEN_W),
    .OFS_W   (OFS_W),
    .CNT_W   (CNT_W),
    .PTR_NUM (PTR_NUM),
    .PG_W    (PG_W)
) i_xov_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .adv_ok_i    (adv_ok_i),
    .adv_bytes_i (adv_bytes_i),
    .len_o       (len_o),
    .tog_o       (tog_o),
    .ofs_o       (ofs_o),
    .page_o      (page_o),
    .err_o       (err_o)
);

// File: tb/test_xfer_overlay_adv.sv
module test_xfer_overlay_adv;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         load_i = 1'b0;
    logic [14:0]  load_len_i = '0;
    logic         load_tog_i = 1'b0;
    logic [11:0]  load_ofs_i = '0;
    logic [2:0]   load_page_i = '0;
    logic [99:0]  load_ptr_i = '0;
    logic         adv_i = 1'b0;
    logic         adv_ok_i = 1'b0;
    logic [10:0]  adv_bytes_i = '0;
    logic [14:0]  len_o;
    logic         tog_o;
    logic [11:0]  ofs_o;
    logic [2:0]   page_o;
    logic [31:0]  addr_o;
    logic         err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_len, m_tog, m_ofs, m_page, m_err;

    always #2 clk_i = ~clk_i;

    xfer_overlay_adv i_xfer_overlay_adv (
        .clk_i, .rst_ni, .load_i, .load_len_i, .load_tog_i, .load_ofs_i,
        .load_page_i, .load_ptr_i, .adv_i, .adv_ok_i, .adv_bytes_i,
        .len_o, .tog_o, .ofs_o, .page_o, .addr_o, .err_o
    );

    function automatic int ptr_val(int n);
        return 32'hA0000 + n * 32'h111;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " R2 len"}, len_o, m_len);
        chk({tag, " R3 tog"}, tog_o, m_tog);
        chk({tag, " R4 ofs"}, ofs_o, m_ofs);
        chk({tag, " R5 page"}, page_o, m_page);
        chk({tag, " R8 err"}, err_o, m_err);
        chk({tag, " R9 addr"}, addr_o, (longint'(ptr_val(m_page)) << 12) + m_ofs);
    endtask

    task automatic do_load(int len, int tog, int ofs, int page);
        @(negedge clk_i);
        load_i = 1'b1; load_len_i = 15'(len); load_tog_i = tog[0];
        load_ofs_i = 12'(ofs); load_page_i = 3'(page);
        @(posedge clk_i); #1;
        load_i = 1'b0;
        m_len = len; m_tog = tog; m_ofs = ofs; m_page = (page > 4) ? 4 : page; m_err = 0;
    endtask

    task automatic do_adv(int ok, int bytes);
        @(negedge clk_i);
        adv_i = 1'b1; adv_ok_i = ok[0]; adv_bytes_i = 11'(bytes);
        @(posedge clk_i); #1;
        adv_i = 1'b0; adv_ok_i = 1'b0;
        if (ok != 0) begin
            if (bytes > m_len) begin m_len = 0; m_err = 1; end
            else m_len = m_len - bytes;
            m_tog = 1 - m_tog;
            m_ofs = m_ofs + bytes;
            if (m_ofs >= 4096) begin
                m_ofs = m_ofs - 4096;
                if (m_page < 4) m_page++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ofs_set[5] = '{0, 1, 2047, 4094, 4095};
        int byt_set[5] = '{0, 1, 512, 1023, 2047};
        int len_set[3] = '{0, 600, 32767};
        int pg_set[3]  = '{0, 3, 4};
        int lfsr = 32'h1ACE;

        for (int n = 0; n < 5; n++) load_ptr_i[n*20 +: 20] = 20'(ptr_val(n));
        repeat (3) @(posedge clk_i);
        #1;
        // R1: reset state
        chk("R1 reset len", len_o, 0);
        chk("R1 reset tog", tog_o, 0);
        chk("R1 reset page", page_o, 0);
        chk("R1 reset addr", addr_o, 0);
        rst_ni = 1'b1;

        // R1: load with page clamp
        do_load(1234, 1, 77, 7);
        chk_all("R1 load");

        // sweep: R2 R3 R4 R5 R7 R8 R9
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 3; c++)
                    for (int p = 0; p < 3; p++) begin
                        do_load(len_set[c], (a + b) & 1, ofs_set[a], pg_set[p]);
                        do_adv(1, byt_set[b]);
                        chk_all("sweep");
                    end

        // R6: discarded advance changes nothing
        do_load(900, 0, 4000, 2);
        do_adv(0, 500);
        chk_all("R6 drop");
        do_adv(1, 1000);
        do_adv(0, 2047);
        chk_all("R6 drop after overrun");

        // R7: zero bytes with zero total
        do_load(0, 1, 4095, 4);
        do_adv(1, 0);
        chk_all("R7 zero");

        // R8: sticky error until load
        do_load(10, 0, 0, 0);
        do_adv(1, 11);
        do_adv(1, 0);
        chk_all("R8 sticky");
        do_load(10, 0, 0, 0);
        chk_all("R8 cleared by load");

        // R10: load and advance together
        @(negedge clk_i);
        load_i = 1'b1; load_len_i = 15'd300; load_tog_i = 1'b0;
        load_ofs_i = 12'd4090; load_page_i = 3'd1;
        adv_i = 1'b1; adv_ok_i = 1'b1; adv_bytes_i = 11'd100;
        @(posedge clk_i); #1;
        load_i = 1'b0; adv_i = 1'b0; adv_ok_i = 1'b0;
        m_len = 300; m_tog = 0; m_ofs = 4090; m_page = 1; m_err = 0;
        chk_all("R10 collide");

        // pseudo-random run
        do_load(32767, 0, 0, 0);
        for (int k = 0; k < 400; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            if ((k % 97) == 96) do_load(lfsr & 16'h7FFF, lfsr & 1, (lfsr >> 3) & 12'hFFF, (lfsr >> 5) & 7);
            else do_adv(((lfsr >> 2) & 7) != 0, (lfsr >> 4) & 11'h7FF);
            chk_all("random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule